// File: doc/BRIEF.md
# DMA Channel Trigger Conditioner

This block decides when one DMA channel may move data. It picks one of twelve hardware trigger lines with a per-channel selector. It applies a programmable polarity, then edge or level sensing. The result is merged with a software trigger strobe and a gated peripheral request line. A pending trigger is held in a trigger flag. Software can see this flag in a status word and can clear it.

Whenever the flag is set, or the enabled peripheral request is high, and no grant is outstanding, the block issues a grant toward a downstream transfer engine. The grant carries the number of transfers to perform. That number is one in single mode, and 2^n in burst mode. The grant is held until the engine answers with a done pulse. Address generation and bus access belong to the engine, not to this block.

Configuration lives in two registers, a 4-bit source select and a 12-bit channel configuration word. Both are written through simple write strobes and take effect on the next clock.

Top module: `dma_trig_cond`

## Requirements
- R1: After a synchronous reset, `grant_req` is 0 and `status` is 0. The select register resets to 15, which means no source. The configuration register resets to all zeros.
- R2: A select value from 0 to 11 routes `hw_trig[select]` into the trigger path. A select value from 12 to 15 selects no source, and no input activity then produces a grant.
- R3: Configuration bit 1 enables hardware triggering, and with it clear no hardware input causes a grant. Configuration bit 0 gates `periph_req`, and with it clear that line has no effect.
- R4: Configuration bit 4 sets polarity. With 0, the selected input is active when low and edge detection reacts to a falling edge. With 1, it is active when high and edge detection reacts to a rising edge.
- R5: Configuration bit 5 clear selects edge sensing. Each inactive-to-active change of the selected input, seen between two successive clocks, produces exactly one trigger. An input that stays active produces no further triggers.
- R6: Configuration bit 5 set selects level sensing. The trigger flag is set again on every clock while the input stays active, so grants keep following one another. Grants stop once the input goes inactive and the last pending flag has been served.
- R7: The grant length is 1 when configuration bit 6 is 0. When bit 6 is 1, the length is 2^n, with n read from configuration bits 11:8. Any n above 10 is treated as 10, giving a length of 1024.
- R8: A `sw_trig` pulse sets the trigger flag with no hardware event. A `clr_trig` pulse clears the flag, and it wins over any set that arrives in the same cycle.
- R9: `status` bit 2 shows the trigger flag, bit 1 shows an outstanding grant, and bit 0 is high when hardware triggering is enabled and the select value is 0 to 11.
- R10: A grant starts one clock after a pending flag or an enabled peripheral request is seen with no grant outstanding. Issuing the grant clears the flag unless a new trigger arrives in that same cycle. `grant_req` and `grant_len` then stay steady until a cycle in which `grant_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Write strobe for the source select register |
| sel_wdata | input | 4 | New source select value |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 12 | New configuration word |
| sw_trig | input | 1 | Software trigger strobe |
| clr_trig | input | 1 | Clear-trigger strobe |
| hw_trig | input | 12 | Raw hardware trigger lines |
| periph_req | input | 1 | Peripheral transfer request |
| grant_done | input | 1 | Engine finished the current grant |
| grant_req | output | 1 | Grant outstanding toward the engine |
| grant_len | output | 11 | Transfers in the current grant |
| status | output | 3 | Flag, busy and armed status bits |

## Verification
A stale copy of the selected input in the edge detector shows up as a missing grant, or an extra grant, one clock after the edge. A flag that fails to clear on hand-off shows up as a second grant one clock after `grant_done`. An error in the burst length calculation appears as a wrong `grant_len` on the very cycle `grant_req` rises. Because the reference model is compared every clock, each of these faults is caught within one or two cycles of the stimulus that exposes it.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int CFG_W  = 12;
  localparam int POW_W  = 4;
  localparam int B_PREQ = 0;
  localparam int B_HWEN = 1;
  localparam int B_POL  = 4;
  localparam int B_LVL  = 5;
  localparam int B_BRST = 6;
  localparam int B_POW  = 8;

  typedef struct packed {
    logic             preq_en;
    logic             hw_en;
    logic             pol_high;
    logic             level;
    logic             burst;
    logic [POW_W-1:0] pow;
  } chan_cfg_t;

  function automatic chan_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    chan_cfg_t c;
    c.preq_en  = w[B_PREQ];
    c.hw_en    = w[B_HWEN];
    c.pol_high = w[B_POL];
    c.level    = w[B_LVL];
    c.burst    = w[B_BRST];
    c.pow      = w[B_POW +: POW_W];
    return c;
  endfunction
endpackage

// File: rtl/dtc_source.sv
module dtc_source #(
  parameter int N_SRC = 12,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol_high,
  input  logic             level,
  input  logic             hw_en,
  input  logic [N_SRC-1:0] hw_trig,
  output logic             sel_ok,
  output logic             hw_event
);
  logic picked;
  logic act;
  logic act_q;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) picked = hw_trig[i];
    end
  end

  assign sel_ok   = (int'(sel) < N_SRC);
  assign act      = sel_ok & (pol_high ? picked : ~picked);
  assign hw_event = hw_en & (level ? act : (act & ~act_q));

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  // R5: an edge trigger can never fire on two successive clocks
  p_one_shot_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (hw_event && !level) |=> !(hw_event && !level));
endmodule

// File: rtl/dtc_flag.sv
module dtc_flag (
  input  logic clk,
  input  logic rst,
  input  logic sw_trig,
  input  logic clr_trig,
  input  logic hw_event,
  input  logic issue,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                     flag <= 1'b0;
    else if (clr_trig)           flag <= 1'b0;
    else if (sw_trig | hw_event) flag <= 1'b1;
    else if (issue)              flag <= 1'b0;
  end

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    clr_trig |=> !flag);
  p_sw_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_trig && !clr_trig) |=> flag);
endmodule

// File: rtl/dtc_grant.sv
module dtc_grant #(
  parameter int MAX_POW = 10,
  parameter int POW_W   = 4,
  parameter int LEN_W   = MAX_POW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag,
  input  logic             preq,
  input  logic             burst,
  input  logic [POW_W-1:0] pow,
  input  logic             done,
  output logic             issue,
  output logic             grant_req,
  output logic [LEN_W-1:0] grant_len
);
  logic [POW_W-1:0] pow_c;
  logic [LEN_W-1:0] len_n;

  assign pow_c = (int'(pow) > MAX_POW) ? POW_W'(MAX_POW) : pow;
  assign len_n = burst ? (LEN_W'(1) << pow_c) : LEN_W'(1);
  assign issue = ~grant_req & (flag | preq);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_req <= 1'b0;
      grant_len <= '0;
    end else if (issue) begin
      grant_req <= 1'b1;
      grant_len <= len_n;
    end else if (grant_req && done) begin
      grant_req <= 1'b0;
    end
  end

  p_hold_until_done_r10: assert property (@(posedge clk) disable iff (rst)
    (grant_req && !done) |=> (grant_req && $stable(grant_len)));
  p_len_power_of_two_r7: assert property (@(posedge clk) disable iff (rst)
    grant_req |-> ($countones(grant_len) == 1));
endmodule

// File: rtl/dma_trig_cond.sv
module dma_trig_cond #(
  parameter int N_SRC   = 12,
  parameter int SEL_W   = 4,
  parameter int MAX_POW = 10,
  parameter int LEN_W   = MAX_POW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel_we,
  input  logic [SEL_W-1:0]         sel_wdata,
  input  logic                     cfg_we,
  input  logic [dtc_pkg::CFG_W-1:0] cfg_wdata,
  input  logic                     sw_trig,
  input  logic                     clr_trig,
  input  logic [N_SRC-1:0]         hw_trig,
  input  logic                     periph_req,
  input  logic                     grant_done,
  output logic                     grant_req,
  output logic [LEN_W-1:0]         grant_len,
  output logic [2:0]               status
);
  import dtc_pkg::*;

  logic [SEL_W-1:0] sel_q;
  chan_cfg_t        cfg_q;
  logic             sel_ok;
  logic             hw_event;
  logic             issue;
  logic             flag;
  logic             unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[3:2], cfg_wdata[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '1;
      cfg_q <= '0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (cfg_we) cfg_q <= unpack_cfg(cfg_wdata);
    end
  end

  dtc_source #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_src (
    .clk(clk), .rst(rst), .sel(sel_q), .pol_high(cfg_q.pol_high),
    .level(cfg_q.level), .hw_en(cfg_q.hw_en), .hw_trig(hw_trig),
    .sel_ok(sel_ok), .hw_event(hw_event));

  dtc_flag u_flag (
    .clk(clk), .rst(rst), .sw_trig(sw_trig), .clr_trig(clr_trig),
    .hw_event(hw_event), .issue(issue), .flag(flag));

  dtc_grant #(.MAX_POW(MAX_POW), .POW_W(POW_W), .LEN_W(LEN_W)) u_grant (
    .clk(clk), .rst(rst), .flag(flag), .preq(cfg_q.preq_en & periph_req),
    .burst(cfg_q.burst), .pow(cfg_q.pow), .done(grant_done),
    .issue(issue), .grant_req(grant_req), .grant_len(grant_len));

  assign status = {flag, grant_req, cfg_q.hw_en & sel_ok};

  // R3: with hardware and peripheral paths both off and no strobe, an idle channel stays idle
  p_gated_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.hw_en && !cfg_q.preq_en && !flag && !sw_trig && !grant_req) |=> !grant_req);
endmodule

// File: tb/test_dma_trig_cond.sv
module test_dma_trig_cond;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_we = 1'b0;
  logic [3:0]  sel_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic        sw_trig = 1'b0;
  logic        clr_trig = 1'b0;
  logic [11:0] hw = '0;
  logic        periph = 1'b0;
  logic        done = 1'b0;
  logic        grant_req;
  logic [10:0] grant_len;
  logic [2:0]  status;

  int checks = 0;
  int fails = 0;
  int gcount = 0;
  int last_len = 0;
  bit auto_done = 1'b1;
  bit prev_req = 1'b0;
  bit finished = 1'b0;

  // reference model state
  int m_sel = 15;
  int m_cfg = 0;
  bit m_prev = 0, m_flag = 0, m_req = 0;
  int m_len = 0;

  always #10 clk = ~clk;

  dma_trig_cond i_dma_trig_cond (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sw_trig(sw_trig),
    .clr_trig(clr_trig), .hw_trig(hw), .periph_req(periph),
    .grant_done(done), .grant_req(grant_req), .grant_len(grant_len),
    .status(status));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 15; m_cfg = 0; m_prev = 0; m_flag = 0; m_req = 0; m_len = 0;
    end else begin
      bit act, ev, issue, nflag;
      int n;
      act = (m_sel < 12) && (m_cfg[4] ? hw[m_sel] : !hw[m_sel]);
      ev = m_cfg[1] && (m_cfg[5] ? act : (act && !m_prev));
      issue = !m_req && (m_flag || (m_cfg[0] && periph));
      if (clr_trig) nflag = 0;
      else if (sw_trig || ev) nflag = 1;
      else if (issue) nflag = 0;
      else nflag = m_flag;
      if (issue) begin
        n = (m_cfg >> 8) & 15;
        if (n > 10) n = 10;
        m_len = m_cfg[6] ? (1 << n) : 1;
        m_req = 1;
      end else if (m_req && done) m_req = 0;
      m_flag = nflag;
      m_prev = act;
      if (sel_we) m_sel = sel_wdata;
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(grant_req == m_req, "R10 grant_req", grant_req, m_req);
      if (m_req) check(grant_len == m_len, "R7 grant_len", grant_len, m_len);
      check(status[2] == m_flag, "R9 flag bit", status[2], m_flag);
      check(status[0] == (m_cfg[1] && m_sel < 12), "R9 armed bit", status[0],
            (m_cfg[1] && m_sel < 12));
      if (grant_req && !prev_req) begin gcount++; last_len = grant_len; end
      prev_req = grant_req;
      done = auto_done && grant_req;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_cfg(input logic [11:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_sel(input logic [3:0] v);
    @(negedge clk); sel_we = 1; sel_wdata = v;
    @(negedge clk); sel_we = 0;
  endtask
  task automatic pulse_sw();
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); clr_trig = 1;
    @(negedge clk); clr_trig = 0;
  endtask
  task automatic finish_test();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    int g0;
    int l0;
    idle(3);
    rst = 0;
    @(negedge clk);
    check(status == 3'b000, "R1 status", status, 0);
    check(grant_req == 1'b0, "R1 grant_req", grant_req, 0);

    // software trigger, single mode
    wr_cfg(12'h000);
    g0 = gcount; pulse_sw(); idle(6);
    check(gcount == g0 + 1, "R8 sw grant count", gcount, g0 + 1);
    check(last_len == 1, "R7 single length", last_len, 1);

    // stalled engine: flag pending, clear, hold
    auto_done = 0;
    g0 = gcount; pulse_sw(); idle(3);
    check(grant_req == 1'b1, "R10 grant raised", grant_req, 1);
    pulse_sw(); idle(2);
    check(status[2] == 1'b1, "R9 pending flag visible", status[2], 1);
    pulse_clr(); idle(2);
    check(status[2] == 1'b0, "R8 clear removes flag", status[2], 0);
    @(negedge clk); sw_trig = 1; clr_trig = 1;
    @(negedge clk); sw_trig = 0; clr_trig = 0;
    idle(1);
    check(status[2] == 1'b0, "R8 clear wins over set", status[2], 0);
    l0 = grant_len; idle(4);
    check(grant_req == 1'b1 && grant_len == l0, "R10 held without done", grant_req, 1);
    auto_done = 1; idle(8);
    check(gcount == g0 + 1, "R8 cleared flag issues nothing", gcount, g0 + 1);

    // edge sensing, rising, source 3
    hw = '0; wr_sel(4'd3); wr_cfg(12'h012); idle(3);
    g0 = gcount; hw[3] = 1; idle(8);
    check(gcount == g0 + 1, "R5 one grant per edge", gcount, g0 + 1);
    hw[3] = 0; idle(4);
    g0 = gcount; hw[4] = 1; idle(4); hw[4] = 0; idle(4);
    check(gcount == g0, "R2 unselected input ignored", gcount, g0);

    wr_sel(4'd11); idle(2);
    g0 = gcount; hw[11] = 1; idle(4); hw[11] = 0; idle(4);
    check(gcount == g0 + 1, "R2 source 11 routed", gcount, g0 + 1);
    wr_sel(4'd0); idle(2);
    g0 = gcount; hw[0] = 1; idle(4); hw[0] = 0; idle(4);
    check(gcount == g0 + 1, "R2 source 0 routed", gcount, g0 + 1);
    wr_sel(4'd13); idle(2);
    g0 = gcount; hw = '1; idle(4); hw = '0; idle(4);
    check(gcount == g0, "R2 select 13 has no source", gcount, g0);
    check(status[0] == 1'b0, "R9 not armed for select 13", status[0], 0);

    // gating bits
    wr_sel(4'd3); wr_cfg(12'h010); idle(2);
    g0 = gcount; hw[3] = 1; idle(4); hw[3] = 0; idle(4);
    check(gcount == g0, "R3 hw path gated", gcount, g0);
    periph = 1; idle(8);
    check(gcount == g0, "R3 periph path gated", gcount, g0);
    wr_cfg(12'h011); idle(10);
    check(gcount >= g0 + 2, "R3 periph path enabled", gcount, g0 + 2);
    periph = 0; idle(6);

    // falling-edge polarity
    hw = '1; wr_cfg(12'h002); idle(3);
    g0 = gcount; hw[3] = 0; idle(8);
    check(gcount == g0 + 1, "R4 falling edge triggers", gcount, g0 + 1);
    hw[3] = 1; idle(6);
    check(gcount == g0 + 1, "R4 rising edge ignored", gcount, g0 + 1);

    // level sensing, burst of 4
    hw = '0; wr_cfg(12'h272); idle(3);
    g0 = gcount; hw[3] = 1; idle(20);
    check(gcount >= g0 + 3, "R6 level re-arms", gcount, g0 + 3);
    check(last_len == 4, "R7 burst of 4", last_len, 4);
    hw[3] = 0; idle(10);
    g0 = gcount; idle(15);
    check(gcount == g0, "R6 stops after release", gcount, g0);

    // burst length clamp and extremes
    wr_cfg(12'hD52); idle(3);
    hw[3] = 1; idle(6); hw[3] = 0; idle(4);
    check(last_len == 1024, "R7 n=13 clamped", last_len, 1024);
    wr_cfg(12'hA52); idle(3);
    hw[3] = 1; idle(6); hw[3] = 0; idle(4);
    check(last_len == 1024, "R7 n=10", last_len, 1024);
    wr_cfg(12'h052); idle(3);
    hw[3] = 1; idle(6); hw[3] = 0; idle(4);
    check(last_len == 1, "R7 n=0 burst", last_len, 1);

    finish_test();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end
endmodule